// File: doc/BRIEF.md
# Tri-State PWM Level Decoder

This block sits behind a pair of comparators that classify the PWM control line of a synchronous buck power stage into three levels: low, mid-window (the controller has let the line float) and high. It turns that classified level into a high-side switch command and a low-side switch command, with a dead-time gap between them. It also raises a status flag when it has decided that the controller has released the line.

A high level selects the high-side switch and a low level selects the low-side switch. A short stay in the mid window leaves the present choice in place. If the mid window lasts for a programmable number of clock cycles, the block switches both sides off and raises the flag. It then waits for a high level before it switches again. A low level is not enough to bring it back. The block comes out of reset in this same off state, so a stage that powers up with a floating or low control line stays quiet until the controller drives its first high.

Top module: `pwm_tri_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, both commands are off and `tri_flag` is 1 after that edge.
- R2: After reset and before the first high code (2'b10), the low code (2'b00) and both mid codes (2'b01, 2'b11) hold both commands off and keep `tri_flag` at 1.
- R3: A high code (2'b10) sampled at an edge clears `tri_flag` after that edge. Once any dead-time gap has run out, `hs_on` is 1 and `ls_on` is 0.
- R4: In normal operation a low code (2'b00) selects the low-side switch: `ls_on` is 1 and `hs_on` is 0 once the dead-time gap has run out.
- R5: In normal operation, a mid code (2'b01 or 2'b11) held for fewer than HOLD_CYC consecutive samples leaves both commands and `tri_flag` unchanged.
- R6: The HOLD_CYC-th consecutive mid sample sets `tri_flag` after that edge, and both commands are off one edge later.
- R7: Any non-mid sample clears the mid-window count, so a later window needs HOLD_CYC fresh consecutive mid samples to trip.
- R8: Once `tri_flag` is set, low and mid codes keep both commands off and the flag set. Only a high code restores switching.
- R9: `hs_on` and `ls_on` are never 1 together. When the selected side changes, both are off for exactly DEAD_CYC cycles before the new side turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, asserted at power-up |
| pwm_lvl | input | 2 | Classified input level: 00 low, 01 or 11 mid window, 10 high |
| hs_on | output | 1 | High-side switch command |
| ls_on | output | 1 | Low-side switch command |
| tri_flag | output | 1 | Set while the block holds both switches off for a released line |

## Verification
The hardest case to reach is the exact trip boundary of the mid-window timer. It has to be shown both ways: a window one sample short of HOLD_CYC must not trip, and the very next sample must trip. The stimulus first drives a window of HOLD_CYC-1 samples, then breaks it with a single low sample and drives another HOLD_CYC-1 mid samples, so a counter that missed its restart would trip early. It then completes the window with the alternate mid code. A cycle-by-cycle behavioural model in the bench follows every sample, including the dead-time gaps on each change of side.

// File: rtl/pwm_tri_pkg.sv
`timescale 1ns/1ps
package pwm_tri_pkg;

    // Comparator classification of the control line
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_MIDX = 2'b11
    } lvl_code_e;

    // Which switch the decoder currently selects
    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_HS  = 2'b01,
        MODE_LS  = 2'b10
    } drive_mode_e;

    typedef struct packed {
        logic ls;
        logic hs;
    } gate_pair_t;

    // Both mid codes have bit 0 set
    function automatic logic is_window(input logic [1:0] code);
        return code[0];
    endfunction

    function automatic logic is_high(input logic [1:0] code);
        return code == LVL_HIGH;
    endfunction

    function automatic gate_pair_t want_of(input drive_mode_e mode);
        gate_pair_t g;
        g.hs = (mode == MODE_HS);
        g.ls = (mode == MODE_LS);
        return g;
    endfunction

endpackage

// File: rtl/pwm_window_timer.sv
`timescale 1ns/1ps
module pwm_window_timer
    import pwm_tri_pkg::*;
#(
    parameter int HOLD_CYC = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lvl,
    output logic       expire
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_q;

    // cnt_q holds the number of consecutive mid samples seen, saturating at LAST
    assign expire = is_window(lvl) && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!is_window(lvl)) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        !is_window(lvl) |=> cnt_q == '0) else $error("window count not cleared"); // R7

    AST_NO_EARLY_TRIP: assert property (@(posedge clk) disable iff (rst)
        (is_window(lvl) && $past(!is_window(lvl))) |-> !expire) else $error("trip on first mid sample"); // R5

endmodule

// File: rtl/pwm_mode_fsm.sv
`timescale 1ns/1ps
module pwm_mode_fsm
    import pwm_tri_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  lvl,
    input  logic        expire,
    output drive_mode_e mode
);
    drive_mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        if (is_high(lvl)) begin
            mode_d = MODE_HS;
        end else if (mode_q != MODE_OFF) begin
            if (!is_window(lvl)) begin
                mode_d = MODE_LS;
            end else if (expire) begin
                mode_d = MODE_OFF;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode = mode_q;

    AST_LATCHED_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_OFF && !is_high(lvl)) |=> mode_q == MODE_OFF) else $error("left off state without high"); // R8

    AST_TRIP_OFF: assert property (@(posedge clk) disable iff (rst)
        expire |=> mode_q == MODE_OFF) else $error("expired window did not switch off"); // R6

    AST_HIGH_SELECTS: assert property (@(posedge clk) disable iff (rst)
        is_high(lvl) |=> mode_q == MODE_HS) else $error("high did not select high side"); // R3

endmodule

// File: rtl/pwm_deadtime.sv
`timescale 1ns/1ps
module pwm_deadtime
    import pwm_tri_pkg::*;
#(
    parameter int DEAD_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  drive_mode_e mode,
    output logic        hs_cmd,
    output logic        ls_cmd
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] GAP_LAST = DW'(DEAD_CYC - 1);

    gate_pair_t  want;
    logic [1:0]  want_v;
    logic [1:0]  cmd;
    logic [DW-1:0] gap_q;
    logic        gap_done;

    assign want     = want_of(mode);
    assign want_v   = {want.ls, want.hs};
    assign gap_done = (gap_q == GAP_LAST);

    // gap_q counts cycles with both sides off; reset leaves it expired
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_LAST;
        end else if (|cmd) begin
            gap_q <= '0;
        end else if (!gap_done) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_side
        logic on_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                on_q <= 1'b0;
            end else if (!want_v[i]) begin
                on_q <= 1'b0;
            end else if (cmd == 2'b00 && gap_done) begin
                on_q <= 1'b1;
            end
        end
        assign cmd[i] = on_q;
    end

    assign hs_cmd = cmd[0];
    assign ls_cmd = cmd[1];

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !(hs_cmd && ls_cmd)) else $error("both sides on"); // R9

    AST_GAP_BEFORE_ON: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_cmd) || $rose(ls_cmd)) |-> $past(cmd == 2'b00)) else $error("no gap before turn-on"); // R9

endmodule

// File: rtl/pwm_tri_decoder.sv
`timescale 1ns/1ps
module pwm_tri_decoder
    import pwm_tri_pkg::*;
#(
    parameter int HOLD_CYC = 30,
    parameter int DEAD_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] pwm_lvl,
    output logic       hs_on,
    output logic       ls_on,
    output logic       tri_flag
);
    logic        expire;
    drive_mode_e mode;

    pwm_window_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .lvl    (pwm_lvl),
        .expire (expire)
    );

    pwm_mode_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .lvl    (pwm_lvl),
        .expire (expire),
        .mode   (mode)
    );

    pwm_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .hs_cmd (hs_on),
        .ls_cmd (ls_on)
    );

    assign tri_flag = (mode == MODE_OFF);

    AST_FLAG_MEANS_OFF: assert property (@(posedge clk) disable iff (rst)
        (tri_flag && $past(tri_flag)) |-> (!hs_on && !ls_on)) else $error("switching while flagged"); // R6

    AST_POWERUP_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !is_high(pwm_lvl)) |=> tri_flag) else $error("left power-up state without high"); // R2

endmodule

// File: tb/pwm_tri_decoder_test.sv
`timescale 1ns/1ps
module pwm_tri_decoder_test;
    localparam int HOLD = 30;
    localparam int DEAD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lvl = 2'b00;
    logic       hs, ls, trif;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    int m_mode = 0;   // 0 off, 1 high side, 2 low side
    int m_run  = 0;
    int m_off  = DEAD - 1;
    bit m_hs   = 0;
    bit m_ls   = 0;

    always #2.5 clk = ~clk;

    pwm_tri_decoder #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) uut (
        .clk(clk), .rst(rst), .pwm_lvl(lvl),
        .hs_on(hs), .ls_on(ls), .tri_flag(trif)
    );

    always @(posedge clk) begin
        int nm, noff;
        bit mid, hi, nhs, nls;
        if (rst) begin
            m_mode = 0; m_run = 0; m_off = DEAD - 1; m_hs = 0; m_ls = 0;
        end else begin
            mid  = lvl[0];
            hi   = (lvl == 2'b10);
            noff = (m_hs || m_ls) ? 0 : ((m_off < DEAD - 1) ? m_off + 1 : m_off);
            nhs  = m_hs;
            nls  = m_ls;
            if (m_mode != 1) nhs = 0;
            else if (!m_hs && !m_ls && m_off == DEAD - 1) nhs = 1;
            if (m_mode != 2) nls = 0;
            else if (!m_hs && !m_ls && m_off == DEAD - 1) nls = 1;
            nm = m_mode;
            if (hi) nm = 1;
            else if (m_mode != 0) begin
                if (!mid) nm = 2;
                else if (m_run + 1 >= HOLD) nm = 0;
            end
            m_run  = mid ? ((m_run < HOLD) ? m_run + 1 : m_run) : 0;
            m_mode = nm;
            m_off  = noff;
            m_hs   = nhs;
            m_ls   = nls;
        end
    end

    // per-cycle comparison against the model (R3 R4 R6 R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            n_run++;
            if (hs !== m_hs || ls !== m_ls || trif !== (m_mode == 0)) begin
                n_fail++;
                $display("FAIL model R3 R4 R6 R9 at %0t: hs/ls/flag %b%b%b expected %b%b%b",
                         $time, hs, ls, trif, m_hs, m_ls, (m_mode == 0));
            end
        end
    end

    task automatic check3(input string tag, input logic ehs, input logic els, input logic etri);
        n_run++;
        if (hs !== ehs || ls !== els || trif !== etri) begin
            n_fail++;
            $display("FAIL %s: hs/ls/flag %b%b%b expected %b%b%b", tag, hs, ls, trif, ehs, els, etri);
        end
    endtask

    task automatic drive(input logic [1:0] v, input int n);
        lvl = v;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int offs;
        @(negedge clk);
        repeat (3) @(negedge clk);
        check3("R1 reset state", 0, 0, 1);
        rst = 1'b0;

        drive(2'b00, 10);       check3("R2 low before first high", 0, 0, 1);
        drive(2'b01, HOLD + 5); check3("R2 window before first high", 0, 0, 1);
        drive(2'b11, 3);        check3("R2 alternate mid code", 0, 0, 1);

        drive(2'b10, 1);        check3("R3 flag clears, command one edge later", 0, 0, 0);
        drive(2'b10, 1);        check3("R3 high side on", 1, 0, 0);
        drive(2'b10, 5);

        // dead-time gap on high-to-low change
        lvl  = 2'b00;
        offs = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!hs && !ls) offs++;
            if (ls) break;
        end
        n_run++;
        if (offs != DEAD) begin
            n_fail++;
            $display("FAIL R9 gap cycles: %0d expected %0d", offs, DEAD);
        end
        check3("R4 low side on", 0, 1, 0);
        drive(2'b00, 5);

        drive(2'b01, HOLD - 1); check3("R5 window one short keeps low side", 0, 1, 0);
        drive(2'b00, 1);
        drive(2'b01, HOLD - 1); check3("R7 excursion restarted count", 0, 1, 0);
        drive(2'b11, 1);        check3("R6 flag at hold count", 0, 1, 1);
        drive(2'b01, 1);        check3("R6 both off", 0, 0, 1);

        drive(2'b00, 40);       check3("R8 low does not restore", 0, 0, 1);
        drive(2'b01, 5);        check3("R8 mid does not restore", 0, 0, 1);
        drive(2'b10, 1);        check3("R8 high clears flag", 0, 0, 0);
        drive(2'b10, 1);        check3("R8 switching restored", 1, 0, 0);

        drive(2'b11, HOLD - 1); check3("R5 window one short keeps high side", 1, 0, 0);
        drive(2'b10, 1);
        drive(2'b01, HOLD);     check3("R6 trip from high side", 1, 0, 1);
        drive(2'b01, 1);        check3("R6 high side dropped", 0, 0, 1);

        drive(2'b10, 4);
        rst = 1'b1;
        drive(2'b10, 2);        check3("R1 reset during switching", 0, 0, 1);
        rst = 1'b0;
        drive(2'b00, 3);        check3("R2 low after reset", 0, 0, 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule